// File: doc/BRIEF.md
# Bit-Serial Twiddle Exponent Generator

This block produces the twiddle-factor exponent `p` for one butterfly column of a bit-serial FFT processor. It also produces the two's-complement value `-p`. A start strobe captures an unsigned index `k1` and a stage number `s`. The index is then moved right inside a shift register, one position per clock, until it has moved `s-1` places. The vacated high bits fill with zeros.

Once aligned, the register drains least significant bit first over a word of `IDX_W` clocks. The word is 9 bits by default. A single borrow flip-flop forms `0 - p` on the same clocks, so both streams leave the block side by side. A downstream coefficient unit takes the two serial streams while the valid flag is high. It closes its word on the last-bit flag.

Top module: `twexp_gen`

## Requirements
- R1: After reset is released, `validOut` and `lastOut` are low, and they stay low until a start is accepted.
- R2: A start accepted in idle captures `k1In` and `stageIn`. The shift amount is `a = s-1`, except that stage 0 is treated like stage 1, giving `a = 0`. The first valid bit appears in the clock cycle `a+1` cycles after the capturing edge.
- R3: While `validOut` is high, `pBit` carries `k1 >> a`, least significant bit first, over exactly `IDX_W` consecutive valid cycles. Vacated high bits are zero, so a stage above `IDX_W` gives `p = 0`.
- R4: On the same cycles, `negBit` carries `(2^IDX_W - p) mod 2^IDX_W`, least significant bit first.
- R5: `lastOut` is high only on the cycle that carries the most significant bit. `validOut` is low on the cycle after it.
- R6: When `p = 0`, `negBit` is 0 on every bit of the word, and the final borrow is discarded.
- R7: The borrow is cleared at every start. A word's negation does not depend on earlier words.
- R8: A start asserted while a word is being aligned or output is ignored. The running word completes with its own values.
- R9: On the first valid bit of every word, `negBit` equals `pBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture strobe for index and stage |
| k1In | input | IDX_W | Unsigned index to be scaled |
| stageIn | input | CNT_W | Stage number s (0 behaves as 1) |
| pBit | output | 1 | Serial exponent, LSB first |
| negBit | output | 1 | Serial two's-complement of the exponent, LSB first |
| validOut | output | 1 | High while a serial bit is present |
| lastOut | output | 1 | High on the most significant bit of the word |

## Verification
The bench feeds several kinds of index:
- an odd index, where the borrow starts at the very first bit;
- an index with low zeros, where negation leaves the low bits unchanged until the first one;
- an all-ones index;
- a zero exponent.

A design that dropped the borrow would output `p` instead of `-p`. A design that sign-filled the vacated bits would show ones in the high bits of large indices. Stage 0, stage 1 and stages beyond the word width are run to catch an off-by-one in the alignment count, which would appear as wrong latency or a doubly shifted value. A zero-exponent word directly after a word that ends with the borrow set catches a borrow that is not cleared: its `-p` would come out as all ones. A second start raised in the middle of a word checks that the running word is not reloaded or cut short.

// File: rtl/twexp_pkg.sv
package twexp_pkg;
  typedef struct packed {
    logic load;      // capture index into shift register
    logic shift;     // move register one place right
    logic clrBorrow; // clear the serial subtractor borrow
    logic emit;      // current LSB is a valid output bit
    logic last;      // current LSB is the word's MSB
  } twexpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_EMIT  = 2'd2
  } twexpState_e;
endpackage

// File: rtl/twexp_ctrl.sv
module twexp_ctrl
  import twexp_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int CNT_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] stageIn,
  output twexpStrobe_t     strb
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IDX_W - 1);

  twexpState_e stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] shiftAmt;

  always_comb begin
    shiftAmt = (stageIn == '0) ? '0 : stageIn - 1'b1;
  end

  always_comb begin
    strb = '0;
    unique case (stateQ)
      ST_IDLE: begin
        strb.load      = start;
        strb.clrBorrow = start;
      end
      ST_ALIGN: strb.shift = 1'b1;
      ST_EMIT: begin
        strb.shift = 1'b1;
        strb.emit  = 1'b1;
        strb.last  = (cntQ == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (start) begin
          if (shiftAmt == '0) begin
            stateQ <= ST_EMIT;
            cntQ   <= LAST_IDX;
          end else begin
            stateQ <= ST_ALIGN;
            cntQ   <= shiftAmt - 1'b1;
          end
        end
        ST_ALIGN: begin
          if (cntQ == '0) begin
            stateQ <= ST_EMIT;
            cntQ   <= LAST_IDX;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        ST_EMIT: begin
          if (cntQ == '0) stateQ <= ST_IDLE;
          else            cntQ   <= cntQ - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twexp_dpath.sv
module twexp_dpath
  import twexp_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] k1In,
  input  twexpStrobe_t     strb,
  output logic             pBit,
  output logic             negBit,
  output logic             validOut,
  output logic             lastOut
);
  logic [IDX_W-1:0] idxQ;
  logic             borrowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= '0;
      borrowQ <= 1'b0;
    end else begin
      if (strb.load)       idxQ <= k1In;
      else if (strb.shift) idxQ <= {1'b0, idxQ[IDX_W-1:1]};
      if (strb.clrBorrow)  borrowQ <= 1'b0;
      else if (strb.emit)  borrowQ <= idxQ[0] | borrowQ;
    end
  end

  // serial 0 - p: difference bit and borrow out
  always_comb begin
    pBit     = strb.emit & idxQ[0];
    negBit   = strb.emit & (idxQ[0] ^ borrowQ);
    validOut = strb.emit;
    lastOut  = strb.last;
  end
endmodule

// File: rtl/twexp_gen.sv
module twexp_gen
  import twexp_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int CNT_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] k1In,
  input  logic [CNT_W-1:0] stageIn,
  output logic             pBit,
  output logic             negBit,
  output logic             validOut,
  output logic             lastOut
);
  twexpStrobe_t strb;

  twexp_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stageIn(stageIn), .strb(strb)
  );

  twexp_dpath #(.IDX_W(IDX_W)) i_dpath (
    .clk(clk), .rstN(rstN), .k1In(k1In), .strb(strb),
    .pBit(pBit), .negBit(negBit), .validOut(validOut), .lastOut(lastOut)
  );
endmodule

// File: rtl/twexp_gen_chk.sv
module twexp_gen_chk (
  input logic clk,
  input logic rstN,
  input logic pBit,
  input logic negBit,
  input logic validOut,
  input logic lastOut
);
  AST_LAST_IN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> validOut); // R5
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |=> !validOut); // R5
  AST_WORD_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !lastOut) |=> validOut); // R3
  AST_FIRST_BIT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !$past(validOut)) |-> (negBit == pBit)); // R9
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (!pBit && !negBit)); // R3
endmodule

bind twexp_gen twexp_gen_chk i_chk (
  .clk(clk), .rstN(rstN), .pBit(pBit), .negBit(negBit),
  .validOut(validOut), .lastOut(lastOut)
);

// File: tb/test_twexp_gen.sv
module test_twexp_gen;
  localparam int IDX_W = 9;
  localparam int CNT_W = $clog2(IDX_W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0] k1In = '0;
  logic [CNT_W-1:0] stageIn = '0;
  logic pBit, negBit, validOut, lastOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  twexp_gen #(.IDX_W(IDX_W)) i_twexp_gen (
    .clk(clk), .rstN(rstN), .start(start), .k1In(k1In), .stageIn(stageIn),
    .pBit(pBit), .negBit(negBit), .validOut(validOut), .lastOut(lastOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one word: capture, optional intrusive start, collect and compare
  task automatic runWord(input int k1, input int stg, input bit poke, input string tag);
    int amt = (stg == 0) ? 0 : stg - 1;
    int expP = (amt >= IDX_W) ? 0 : (k1 >> amt);
    int expN = (-expP) & ((1 << IDX_W) - 1);
    int gotP = 0, gotN = 0, nBits = 0, firstIdx = -1, lastIdx = -1;
    @(negedge clk);
    start = 1'b1; k1In = IDX_W'(k1); stageIn = CNT_W'(stg);
    @(negedge clk);
    start = 1'b0;
    for (int idx = 1; idx <= 30; idx++) begin
      if (poke && idx == 3) begin
        start = 1'b1; k1In = '1; stageIn = CNT_W'(1);  // R8 ignored start
      end else if (poke && idx == 4) begin
        start = 1'b0;
      end
      if (validOut) begin
        if (firstIdx < 0) firstIdx = idx;
        if (nBits < IDX_W) begin
          gotP |= int'(pBit) << nBits;
          gotN |= int'(negBit) << nBits;
        end
        if (lastOut) lastIdx = nBits;
        nBits++;
      end
      @(negedge clk);
    end
    check("R2", {tag, " latency"}, firstIdx, amt + 1);
    check("R3", {tag, " p value"}, gotP, expP);
    check("R4", {tag, " -p value"}, gotN, expN);
    check("R5", {tag, " bit count"}, nBits, IDX_W);
    check("R5", {tag, " last position"}, lastIdx, IDX_W - 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "valid after reset", int'(validOut), 0);
    check("R1", "last after reset", int'(lastOut), 0);
  endtask

  task automatic testBasic();
    runWord(9'h1B3, 1, 1'b0, "R3 stage1 odd");
    runWord(9'h1B3, 4, 1'b0, "R3 stage4");
    runWord(9'h0A8, 2, 1'b0, "R4 low zeros");
    runWord(9'h1FF, 3, 1'b0, "R4 all ones");
  endtask

  task automatic testStageEdges();
    runWord(9'h155, 0, 1'b0, "R2 stage0");
    runWord(9'h1FF, 9, 1'b0, "R3 stage9");
    runWord(9'h1FF, 10, 1'b0, "R3 stage10 zero");
  endtask

  task automatic testBorrowClear();
    runWord(9'h001, 1, 1'b0, "R7 borrow set");
    runWord(9'h000, 1, 1'b0, "R6 R7 zero after");
  endtask

  task automatic testBusyStart();
    runWord(9'h0C6, 3, 1'b1, "R8 start while busy");
    repeat (3) @(negedge clk);
    check("R8", "idle after ignored start", int'(validOut), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testStageEdges();
    testBorrowClear();
    testBusyStart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule